// File: doc/BRIEF.md
# MDIO Link Status Polling Engine

This block keeps a live picture of the PHYs on a management bus without any host effort. Once switched on, it walks the 32 PHY addresses in ascending order. For each address that its enable mask allows, it asks a shared MDIO frame shifter to read PHY register 1. When the frame completes, it writes the link bit and the acknowledge outcome into two 32-bit status vectors. The host keeps its own use of the shifter: while the host has a transaction pending, the engine starts no new frame. Host reads that complete also refresh the alive bit of the PHY they addressed.

Two monitor slots each watch one chosen PHY. A slot takes its link indication either from the polled vector or from a dedicated external link input. When that indication changes, the slot sets a sticky raw interrupt bit, which the host clears by writing 1. A masked copy of the bit is driven only when the slot's interrupt enable is set. The serial frame timing and the host bus decode sit outside this block.

Top module: `mdio_link_poller`

## Requirements
- R1: After reset, and for as long as `cfg_enable` is 0, `mdio_req` stays low. In that state `link_vec`, `alive_vec` and `link_irq_raw` hold all zeros.
- R2: While enabled, poll frames go to PHY addresses in ascending order and wrap from 31 to 0. Every frame carries register address 1 on `mdio_reg`. `mdio_req` stays high with a stable `mdio_phy` until `mdio_done`.
- R3: An address whose `cfg_poll_mask` bit is 0 gets no frame. Its bits in both vectors keep their values.
- R4: When a poll frame completes with `mdio_ack`=1, `link_vec[a]` takes bit 2 of `mdio_rdata` and `alive_vec[a]` becomes 1, visible in the next cycle. No other bit changes.
- R5: When a poll frame completes with `mdio_ack`=0, both `link_vec[a]` and `alive_vec[a]` become 0.
- R6: A pulse on `host_rd_done` sets `alive_vec[host_rd_phy]` to the value of `host_rd_ack`. If a poll of the same address completes in the same cycle, the poll result wins.
- R7: While `host_pend` is 1, no new poll frame is started. A frame already in flight still completes.
- R8: A slot with link-select 0 follows `link_vec` at its selected PHY address. A change of that bit sets the slot's `link_irq_raw` bit one cycle after the vector changes.
- R9: A slot with link-select 1 follows its `ext_link` bit, and a change sets its raw bit in the next cycle. Changes in the polled vector then have no effect on that slot.
- R10: `link_irq_masked[m]` equals `link_irq_raw[m]` AND `cfg_mon_inten[m]`.
- R11: A 1 on `irq_clr[m]` clears raw bit m. If a change is detected in the same cycle, the set wins. A clear does not touch the other slot.
- R12: When `cfg_enable` falls during a frame, that frame completes and updates the vectors. No further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Global polling enable |
| cfg_poll_mask | input | 32 | Per-address poll enable |
| cfg_mon_phy | input | 10 | Monitored PHY address per slot, 5 bits each, slot 0 in the low bits |
| cfg_mon_linksel | input | 2 | Per slot: 0 selects the polled link, 1 selects `ext_link` |
| cfg_mon_inten | input | 2 | Per-slot interrupt enable for the masked output |
| irq_clr | input | 2 | Write-1-to-clear strobe for the raw bits |
| host_pend | input | 1 | A host transaction is waiting for the shifter |
| host_rd_done | input | 1 | A host register read has completed (one-cycle pulse) |
| host_rd_phy | input | 5 | PHY address of the completed host read |
| host_rd_ack | input | 1 | Acknowledge result of the completed host read |
| mdio_req | output | 1 | Poll frame request to the shifter, held until done |
| mdio_phy | output | 5 | PHY address of the poll frame |
| mdio_reg | output | 5 | Register address of the poll frame (always 1) |
| mdio_done | input | 1 | Shifter finished the frame (one-cycle pulse) |
| mdio_ack | input | 1 | The PHY acknowledged the read |
| mdio_rdata | input | 16 | Read data of the frame |
| ext_link | input | 2 | External link indication per slot |
| link_vec | output | 32 | Polled link bit per address |
| alive_vec | output | 32 | Acknowledge result per address |
| link_irq_raw | output | 2 | Sticky link-change flags |
| link_irq_masked | output | 2 | Raw flags gated by the interrupt enables |

## Verification
Two functions can meet in one cycle: a detected link change setting a raw bit, and the host's write-1-to-clear of that same bit. The bench provokes the meeting by toggling the external link input of a slot that is already flagged and pulsing its clear strobe at the same negative edge. One cycle later it expects the bit to still be set. A lone clear in the following cycle must then drop the bit and leave the other slot's flag alone.

// File: rtl/mdio_poll_pkg.sv
// Shared constants and types of the MDIO link polling engine.
// Assumes 5-bit PHY and register addresses as on a standard management bus.
package mdio_poll_pkg;
    localparam int unsigned PHY_AW   = 5;
    localparam int unsigned NUM_PHY  = 1 << PHY_AW;
    localparam int unsigned REG_AW   = 5;
    localparam int unsigned RD_W     = 16;
    localparam int unsigned LINK_BIT = 2;
    localparam logic [REG_AW-1:0] STATUS_REG = 5'd1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mdio_poll_seq.sv
// Poll sequencer: walks PHY addresses in ascending order and skips masked-off
// ones at one address per cycle. It issues one status-read request per enabled
// address and holds it until the shifter reports done. It yields to a pending
// host transaction before each new frame.
// Assumes done is a one-cycle pulse that arrives only while req is high.
module mdio_poll_seq
    import mdio_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [NUM_PHY-1:0] poll_mask,
    input  logic              host_pend,
    input  logic              done,
    output logic              req,
    output logic [PHY_AW-1:0] phy,
    output logic              poll_done
);
    seq_state_e        state_q;
    logic [PHY_AW-1:0] ptr_q;

    // Sequencer state and address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (enable) state_q <= SEQ_SCAN;
                SEQ_SCAN: begin
                    if (!enable)                state_q <= SEQ_IDLE;
                    else if (!poll_mask[ptr_q]) ptr_q   <= ptr_q + 1'b1;
                    else if (!host_pend)        state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: if (done) begin
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= SEQ_SCAN;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Request outputs.
    always_comb begin
        req       = (state_q == SEQ_WAIT);
        phy       = ptr_q;
        poll_done = (state_q == SEQ_WAIT) && done;
    end

    a_r1_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(enable));
    a_r7_no_start_under_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !$past(host_pend));
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done) |=> (req && $stable(phy)));
    a_r3_only_enabled_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(poll_mask[phy]));
    a_r12_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !enable) |=> !req);
endmodule

// File: rtl/mdio_status_vec.sv
// Status vectors: one link bit and one alive bit per PHY address. They are
// updated by each completed poll frame and by completed host reads (alive only).
// Assumes poll results and host results may land in the same cycle; the
// poll result wins when both name the same address.
module mdio_status_vec
    import mdio_poll_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll_done,
    input  logic [PHY_AW-1:0]  poll_phy,
    input  logic               poll_ack,
    input  logic               poll_link,
    input  logic               host_done,
    input  logic [PHY_AW-1:0]  host_phy,
    input  logic               host_ack,
    output logic [NUM_PHY-1:0] link_vec,
    output logic [NUM_PHY-1:0] alive_vec
);
    logic [NUM_PHY-1:0] link_d, alive_d;

    // Next values: host update first, poll result overrides.
    always_comb begin
        link_d  = link_vec;
        alive_d = alive_vec;
        if (host_done) alive_d[host_phy] = host_ack;
        if (poll_done) begin
            alive_d[poll_phy] = poll_ack;
            link_d[poll_phy]  = poll_ack & poll_link;
        end
    end

    // Vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_vec  <= '0;
            alive_vec <= '0;
        end else begin
            link_vec  <= link_d;
            alive_vec <= alive_d;
        end
    end

    a_r4_ack_updates: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_done && poll_ack) |=> (alive_vec[$past(poll_phy)] &&
            link_vec[$past(poll_phy)] == $past(poll_link)));
    a_r5_noack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_done && !poll_ack) |=> (!alive_vec[$past(poll_phy)] && !link_vec[$past(poll_phy)]));
    a_r4_link_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_done |=> $stable(link_vec));
    a_r6_host_alive: assert property (@(posedge clk) disable iff (!rst_n)
        (host_done && !(poll_done && poll_phy == host_phy)) |=>
            (alive_vec[$past(host_phy)] == $past(host_ack)));
endmodule

// File: rtl/mdio_link_mon.sv
// Link monitor slot: selects a link indication (polled vector bit or external
// input) and flags any change in a sticky raw bit. The raw bit is cleared by
// write-1 strobe, with set priority. It also drives the enable-gated copy.
// Assumes ext_link is already synchronous to clk.
module mdio_link_mon
    import mdio_poll_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PHY-1:0] link_vec,
    input  logic [PHY_AW-1:0]  phy_sel,
    input  logic               use_ext,
    input  logic               ext_link,
    input  logic               inten,
    input  logic               clr,
    output logic               raw,
    output logic               masked
);
    logic sel_link, prev_q, changed;

    // Source selection and change detection.
    always_comb begin
        sel_link = use_ext ? ext_link : link_vec[phy_sel];
        changed  = (sel_link != prev_q);
        masked   = raw & inten;
    end

    // Previous indication and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            raw    <= 1'b0;
        end else begin
            prev_q <= sel_link;
            raw    <= (raw & ~clr) | changed;
        end
    end

    a_r8_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_link != prev_q) |=> raw);
    a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_link == prev_q && !clr) |=> $stable(raw));
    a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_link == prev_q && clr) |=> !raw);
endmodule

// File: rtl/mdio_link_poller.sv
// Top of the MDIO link polling engine: sequencer, status vectors and NUM_MON
// link monitor slots. Only the link bit of the read data is used; the
// remaining data bits are ignored.
// Assumes a shared shifter that accepts req and answers with a done pulse.
module mdio_link_poller
    import mdio_poll_pkg::*;
#(
    parameter int unsigned NUM_MON = 2
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_enable,
    input  logic [NUM_PHY-1:0]        cfg_poll_mask,
    input  logic [NUM_MON*PHY_AW-1:0] cfg_mon_phy,
    input  logic [NUM_MON-1:0]        cfg_mon_linksel,
    input  logic [NUM_MON-1:0]        cfg_mon_inten,
    input  logic [NUM_MON-1:0]        irq_clr,
    input  logic                      host_pend,
    input  logic                      host_rd_done,
    input  logic [PHY_AW-1:0]         host_rd_phy,
    input  logic                      host_rd_ack,
    output logic                      mdio_req,
    output logic [PHY_AW-1:0]         mdio_phy,
    output logic [REG_AW-1:0]         mdio_reg,
    input  logic                      mdio_done,
    input  logic                      mdio_ack,
    input  logic [RD_W-1:0]           mdio_rdata,
    input  logic [NUM_MON-1:0]        ext_link,
    output logic [NUM_PHY-1:0]        link_vec,
    output logic [NUM_PHY-1:0]        alive_vec,
    output logic [NUM_MON-1:0]        link_irq_raw,
    output logic [NUM_MON-1:0]        link_irq_masked
);
    logic poll_done;
    logic unused_rdata_bits;

    // Fixed status register address; other data bits are unused by design.
    always_comb begin
        mdio_reg          = STATUS_REG;
        unused_rdata_bits = ^mdio_rdata;
    end

    mdio_poll_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .poll_mask (cfg_poll_mask),
        .host_pend (host_pend),
        .done      (mdio_done),
        .req       (mdio_req),
        .phy       (mdio_phy),
        .poll_done (poll_done)
    );

    mdio_status_vec u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_done (poll_done),
        .poll_phy  (mdio_phy),
        .poll_ack  (mdio_ack),
        .poll_link (mdio_rdata[LINK_BIT]),
        .host_done (host_rd_done),
        .host_phy  (host_rd_phy),
        .host_ack  (host_rd_ack),
        .link_vec  (link_vec),
        .alive_vec (alive_vec)
    );

    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
        mdio_link_mon u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .link_vec (link_vec),
            .phy_sel  (cfg_mon_phy[m*PHY_AW +: PHY_AW]),
            .use_ext  (cfg_mon_linksel[m]),
            .ext_link (ext_link[m]),
            .inten    (cfg_mon_inten[m]),
            .clr      (irq_clr[m]),
            .raw      (link_irq_raw[m]),
            .masked   (link_irq_masked[m])
        );
    end
endmodule

// File: tb/mdio_link_poller_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected poll addresses into a queue.
// A responder/monitor process answers frames, pops and compares addresses, and
// checks the status vectors against a model kept from the requirements.
module mdio_link_poller_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_drv = 1'b0, halted = 1'b0;
    logic        cfg_enable;
    logic [31:0] cfg_poll_mask = '1;
    logic [9:0]  cfg_mon_phy = {5'd5, 5'd5};
    logic [1:0]  cfg_mon_linksel = 2'b10;
    logic [1:0]  cfg_mon_inten = 2'b01;
    logic [1:0]  irq_clr = '0;
    logic        host_pend = 1'b0, host_rd_done = 1'b0, host_rd_ack = 1'b0;
    logic [4:0]  host_rd_phy = '0;
    logic        mdio_req, mdio_done = 1'b0, mdio_ack = 1'b0;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_rdata = '0;
    logic [1:0]  ext_link = '0;
    logic [31:0] link_vec, alive_vec;
    logic [1:0]  link_irq_raw, link_irq_masked;

    assign cfg_enable = en_drv & ~halted;

    always #4 clk = ~clk;

    mdio_link_poller u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_poll_mask(cfg_poll_mask),
        .cfg_mon_phy(cfg_mon_phy), .cfg_mon_linksel(cfg_mon_linksel),
        .cfg_mon_inten(cfg_mon_inten), .irq_clr(irq_clr), .host_pend(host_pend),
        .host_rd_done(host_rd_done), .host_rd_phy(host_rd_phy), .host_rd_ack(host_rd_ack),
        .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
        .mdio_done(mdio_done), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
        .ext_link(ext_link), .link_vec(link_vec), .alive_vec(alive_vec),
        .link_irq_raw(link_irq_raw), .link_irq_masked(link_irq_masked)
    );

    int          checks = 0, failures = 0;
    int          n_start = 0, n_done = 0;
    int          exp_q[$];
    logic [4:0]  exp_ptr = '0;
    logic [31:0] phy_ack = '1, phy_link = '0;
    logic [31:0] exp_link = '0, exp_alive = '0;
    bit          finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: push the expected addresses of the next n frames.
    task automatic push_frames(input int n);
        for (int k = 0; k < n; k++) begin
            while (!cfg_poll_mask[exp_ptr]) exp_ptr = exp_ptr + 1'b1;
            exp_q.push_back(int'(exp_ptr));
            exp_ptr = exp_ptr + 1'b1;
        end
    endtask

    task automatic run_until_halt();
        en_drv = 1'b1;
        while (!halted) @(negedge clk);
        en_drv = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Responder and monitor: answers frames after three cycles, checks order and vectors.
    initial begin : responder
        int  lat = 0;
        bit  chk_pend = 0;
        int  a = 0;
        forever begin
            @(negedge clk);
            mdio_done = 1'b0;
            if (chk_pend) begin
                chk("R4 link vector after poll", link_vec, exp_link);
                chk("R4 alive vector after poll", alive_vec, exp_alive);
                chk_pend = 0;
            end
            if (mdio_req) begin
                if (lat == 0) begin
                    n_start++;
                    chk("R2 register address", {27'd0, mdio_reg}, 32'd1);
                    if (exp_q.size() == 0) begin
                        chk("R12 unexpected poll frame", {27'd0, mdio_phy}, 32'hFFFF_FFFF);
                        a = int'(mdio_phy);
                    end else begin
                        a = exp_q.pop_front();
                        chk("R2 R3 poll address order", {27'd0, mdio_phy}, a);
                    end
                end
                lat++;
                if (lat == 3) begin
                    mdio_done  = 1'b1;
                    mdio_ack   = phy_ack[mdio_phy];
                    mdio_rdata = 16'h7809 | (phy_link[mdio_phy] ? 16'h0004 : 16'h0000);
                    exp_alive[mdio_phy] = phy_ack[mdio_phy];
                    exp_link[mdio_phy]  = phy_ack[mdio_phy] & phy_link[mdio_phy];
                    lat = 0;
                    n_done++;
                    chk_pend = 1;
                    if (exp_q.size() == 0) halted = 1'b1;
                end
            end
            if (!en_drv) halted = 1'b0;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : driver
        int s, d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 no request while disabled", n_start, 0);
        chk("R1 link vector reset", link_vec, 32'h0);
        chk("R1 alive vector reset", alive_vec, 32'h0);
        chk("R1 raw flags reset", {30'd0, link_irq_raw}, 32'h0);

        // Full sweep: links on 2, 5, 7, all acknowledge.
        phy_link = 32'h0000_00A4;
        push_frames(32);
        run_until_halt();
        chk("R4 sweep link", link_vec, 32'h0000_00A4);
        chk("R4 sweep alive", alive_vec, 32'hFFFF_FFFF);
        chk("R8 polled change flags slot0", {31'd0, link_irq_raw[0]}, 1);
        chk("R10 masked slot0 enabled", {31'd0, link_irq_masked[0]}, 1);
        chk("R9 external slot ignores polled change", {31'd0, link_irq_raw[1]}, 0);

        // PHY 7 stops acknowledging.
        phy_ack[7] = 1'b0;
        push_frames(32);
        run_until_halt();
        chk("R5 no ack clears link", link_vec, 32'h0000_0024);
        chk("R5 no ack clears alive", alive_vec, 32'hFFFF_FF7F);

        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11 clear slot0", {30'd0, link_irq_raw}, 32'h0);

        // Sparse mask: only 0,2,5,7,12..15 polled.
        cfg_poll_mask = 32'h0000_F0A5;
        phy_link[5] = 1'b0;
        phy_link[0] = 1'b1;
        phy_link[9] = 1'b1;
        phy_ack[9]  = 1'b0;
        push_frames(16);
        run_until_halt();
        chk("R3 masked addresses keep link", link_vec, 32'h0000_0005);
        chk("R3 masked addresses keep alive", alive_vec, 32'hFFFF_FF7F);
        chk("R8 falling link flags slot0", {31'd0, link_irq_raw[0]}, 1);

        // Host pending holds off new frames.
        cfg_poll_mask = '1;
        push_frames(8);
        en_drv = 1'b1;
        s = n_start;
        while (n_start == s) @(negedge clk);
        host_pend = 1'b1;
        @(negedge clk);
        s = n_start;
        d = n_done;
        repeat (30) @(negedge clk);
        chk("R7 no new frame while host pending", n_start, s);
        chk("R7 in-flight frame completes", n_done, d + 1);
        host_pend = 1'b0;
        run_until_halt();
        chk("R7 frames resume", exp_q.size(), 0);

        // Host read completions refresh alive.
        host_rd_phy = 5'd7; host_rd_ack = 1'b1; host_rd_done = 1'b1;
        @(negedge clk);
        host_rd_phy = 5'd12; host_rd_ack = 1'b0;
        @(negedge clk);
        host_rd_done = 1'b0;
        exp_alive[7] = 1'b1;
        chk("R6 host ack sets alive", {31'd0, alive_vec[7]}, 1);
        @(negedge clk);
        exp_alive[12] = 1'b0;
        chk("R6 host no ack clears alive", alive_vec, exp_alive);

        // Disable during a frame.
        push_frames(1);
        en_drv = 1'b1;
        s = n_start;
        d = n_done;
        while (n_start == s) @(negedge clk);
        en_drv = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 frame in flight completes", n_done, d + 1);
        chk("R12 no frame after disable", n_start, s + 1);
        chk("R12 vector updated", link_vec, exp_link);

        // External link slot, enable gating and set-over-clear.
        ext_link[1] = 1'b1;
        @(negedge clk);
        chk("R9 external change flags slot1", {31'd0, link_irq_raw[1]}, 1);
        chk("R10 masked slot1 disabled", {31'd0, link_irq_masked[1]}, 0);
        cfg_mon_inten = 2'b11;
        #1;
        chk("R10 masked slot1 enabled", {31'd0, link_irq_masked[1]}, 1);
        @(negedge clk);
        ext_link[1] = 1'b0;
        irq_clr = 2'b10;
        @(negedge clk);
        chk("R11 set wins over clear", {31'd0, link_irq_raw[1]}, 1);
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11 lone clear drops slot1", {31'd0, link_irq_raw[1]}, 0);
        chk("R11 other slot untouched", {31'd0, link_irq_raw[0]}, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule